// File: doc/BRIEF.md
# Pipeline hazard and forwarding unit

This block is the hazard controller of a five-stage in-order integer pipeline (fetch, decode, execute, memory, write-back). Each cycle it takes the register fields of the pipeline registers: the source register numbers of the instructions in decode and execute, and the destination number and control bits of the instructions in memory and write-back. From these it chooses where the execute-stage operands come from. It holds the front end for one cycle when a load result is needed too early. It also turns wrong-path instructions into no-ops after a taken branch.

Branches are predicted not taken. The execute stage reports a taken decision. The unit registers that decision alongside the branch, and in the following cycle, with the branch in memory, it redirects fetch. In that cycle it clears the three pipeline registers that hold younger instructions. A cleared or bubbled pipeline register carries no register-write or memory-write bit, so it changes no architectural state. All outputs are plain control pins. There is no stream interface, so no valid/ready handshake applies.

Register 0 is hard-wired to zero and never produces a forwarding match. The register file writes in the first half of the cycle and reads in the second. The unit also reports, per decode operand, when the write-back stage is writing that register, so the decode read mux can take the write-back value.

Top module: `hz_unit`

## Requirements
- R1: When an execute source equals the memory-stage destination, the memory stage writes a register (mem_we_i=1), it is not a load and the destination is not 0, that operand's select is 2'b10 (memory path), in the same cycle.
- R2: When no memory-path match exists and the source equals a write-back destination with wb_we_i=1 and destination not 0, the select is 2'b01 (write-back path).
- R3: When both the memory and write-back stages match the same source, the memory path (2'b10) wins.
- R4: A source or destination of 0, or a cleared write bit, never produces a match; with no match the select is 2'b00 (register-file value).
- R5: A load in memory (mem_ld_i=1, mem_we_i=1, destination not 0) whose destination matches either execute source raises pc_hold_o, ifid_hold_o, idex_hold_o and exmem_clear_o in the same cycle, while ifid_clear_o and idex_clear_o stay low.
- R6: A load in the memory stage never yields select 2'b10. The stalled operand is later taken from write-back (2'b01) once the load reaches that stage.
- R7: id_wb_byp_o[i] is 1 exactly when decode source i equals a non-zero write-back destination with wb_we_i=1.
- R8: A taken decision (ex_br_taken_i=1) raised in a cycle with no stall and no redirect makes redirect_o, ifid_clear_o, idex_clear_o and exmem_clear_o all 1 in the next cycle, for exactly one cycle.
- R9: A taken decision raised during a load-use stall is ignored: no redirect follows in the next cycle.
- R10: During a redirect cycle all three holds are 0 even when the load-use condition is present.
- R11: A taken decision raised during a redirect cycle comes from a wrong-path instruction and is ignored.
- R12: During and right after reset, redirect_o is 0 and no clear or hold is raised by an idle pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| id_src_i | input | NUM_SRC x AW | Source register numbers of the decode instruction |
| ex_src_i | input | NUM_SRC x AW | Source register numbers of the execute instruction |
| ex_br_taken_i | input | 1 | Execute-stage branch resolved taken |
| mem_rd_i | input | AW | Destination register of the memory-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_ld_i | input | 1 | Memory-stage instruction is a load |
| wb_rd_i | input | AW | Destination register of the write-back-stage instruction |
| wb_we_i | input | 1 | Write-back-stage instruction writes a register |
| ex_fwd_sel_o | output | NUM_SRC x 2 | Per execute operand: 00 register file, 01 write-back, 10 memory |
| id_wb_byp_o | output | NUM_SRC | Per decode operand: take the write-back value |
| pc_hold_o | output | 1 | Hold the fetch address |
| ifid_hold_o | output | 1 | Hold the fetch/decode register |
| idex_hold_o | output | 1 | Hold the decode/execute register |
| ifid_clear_o | output | 1 | Clear the fetch/decode register to a no-op |
| idex_clear_o | output | 1 | Clear the decode/execute register to a no-op |
| exmem_clear_o | output | 1 | Clear the execute/memory register to a no-op |
| redirect_o | output | 1 | Branch in memory redirects fetch to its target |

## Verification
The only internal state is the registered taken flag, so a fault there shows at the ports one cycle after the execute-stage decision. A missing flag shows as no redirect and no clears. A flag held too long shows as a second redirect cycle. A flag latched during a stall shows as a redirect that should not occur. Faults in the comparators appear in the same cycle on the select and hold pins. The bench therefore compares every output every cycle, and runs directed priority and register-0 cases next to a dense sweep over a small set of register numbers.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Operand source for the execute stage.
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/hz_src_match.sv
// Comparators for one operand slot: execute forwarding select, load hit,
// decode write-back bypass.
module hz_src_match #(
  parameter int AW = 5
) (
  input  logic [AW-1:0]    ex_src,
  input  logic [AW-1:0]    id_src,
  input  logic [AW-1:0]    mem_rd,
  input  logic             mem_we,
  input  logic             mem_ld,
  input  logic [AW-1:0]    wb_rd,
  input  logic             wb_we,
  output hz_pkg::fwd_sel_e fwd_sel,
  output logic             load_hit,
  output logic             id_byp
);
  logic mem_live;
  logic wb_live;
  logic mem_hit;

  assign mem_live = mem_we && (mem_rd != '0);
  assign wb_live  = wb_we && (wb_rd != '0);
  assign mem_hit  = mem_live && (mem_rd == ex_src);

  always_comb begin
    if (mem_hit && !mem_ld)
      fwd_sel = hz_pkg::FWD_MEM;
    else if (wb_live && (wb_rd == ex_src))
      fwd_sel = hz_pkg::FWD_WB;
    else
      fwd_sel = hz_pkg::FWD_RF;
  end

  assign load_hit = mem_hit && mem_ld;
  assign id_byp   = wb_live && (wb_rd == id_src);
endmodule

// File: rtl/hz_branch_ctl.sv
// Registers the execute-stage taken decision so it travels with the branch
// into the memory stage, and arbitrates it against the load-use stall.
module hz_branch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ex_taken,
  input  logic load_use,
  output logic stall,
  output logic redirect
);
  logic taken_q;

  // Redirect wins: the instruction in execute is then on the wrong path.
  assign stall    = load_use && !taken_q;
  assign redirect = taken_q;

  // A stalled decision is re-made after the bubble; a wrong-path one is dropped.
  always_ff @(posedge clk) begin
    if (!rst_n)
      taken_q <= 1'b0;
    else
      taken_q <= ex_taken && !stall && !taken_q;
  end
endmodule

// File: rtl/hz_stage_ctl.sv
// Maps the stall and redirect events onto per-stage hold and clear pins.
module hz_stage_ctl (
  input  logic stall,
  input  logic redirect,
  output logic pc_hold,
  output logic ifid_hold,
  output logic idex_hold,
  output logic ifid_clear,
  output logic idex_clear,
  output logic exmem_clear
);
  // Load-use: front end and execute keep their contents, a bubble enters memory.
  assign pc_hold     = stall;
  assign ifid_hold   = stall;
  assign idex_hold   = stall;
  // Redirect: everything younger than the branch in memory becomes a no-op.
  assign ifid_clear  = redirect;
  assign idex_clear  = redirect;
  assign exmem_clear = redirect || stall;
endmodule

// File: rtl/hz_unit.sv
module hz_unit #(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0][AW-1:0]  id_src_i,
  input  logic [NUM_SRC-1:0][AW-1:0]  ex_src_i,
  input  logic                        ex_br_taken_i,
  input  logic [AW-1:0]               mem_rd_i,
  input  logic                        mem_we_i,
  input  logic                        mem_ld_i,
  input  logic [AW-1:0]               wb_rd_i,
  input  logic                        wb_we_i,
  output logic [NUM_SRC-1:0][1:0]     ex_fwd_sel_o,
  output logic [NUM_SRC-1:0]          id_wb_byp_o,
  output logic                        pc_hold_o,
  output logic                        ifid_hold_o,
  output logic                        idex_hold_o,
  output logic                        ifid_clear_o,
  output logic                        idex_clear_o,
  output logic                        exmem_clear_o,
  output logic                        redirect_o
);
  localparam int SelW = $bits(hz_pkg::fwd_sel_e);

  hz_pkg::fwd_sel_e   sel_w [NUM_SRC];
  logic [NUM_SRC-1:0] load_hit_w;
  logic               load_use_w;
  logic               stall_w;
  logic               redirect_w;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    hz_src_match #(.AW(AW)) u_match (
      .ex_src   (ex_src_i[g]),
      .id_src   (id_src_i[g]),
      .mem_rd   (mem_rd_i),
      .mem_we   (mem_we_i),
      .mem_ld   (mem_ld_i),
      .wb_rd    (wb_rd_i),
      .wb_we    (wb_we_i),
      .fwd_sel  (sel_w[g]),
      .load_hit (load_hit_w[g]),
      .id_byp   (id_wb_byp_o[g])
    );
    assign ex_fwd_sel_o[g] = SelW'(sel_w[g]);
  end

  assign load_use_w = |load_hit_w;

  hz_branch_ctl u_branch (
    .clk      (clk),
    .rst_n    (rst_n),
    .ex_taken (ex_br_taken_i),
    .load_use (load_use_w),
    .stall    (stall_w),
    .redirect (redirect_w)
  );

  hz_stage_ctl u_stage (
    .stall       (stall_w),
    .redirect    (redirect_w),
    .pc_hold     (pc_hold_o),
    .ifid_hold   (ifid_hold_o),
    .idex_hold   (idex_hold_o),
    .ifid_clear  (ifid_clear_o),
    .idex_clear  (idex_clear_o),
    .exmem_clear (exmem_clear_o)
  );

  assign redirect_o = redirect_w;
endmodule

// File: rtl/hz_unit_chk.sv
module hz_unit_chk #(
  parameter int AW      = 5,
  parameter int NUM_SRC = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_SRC-1:0][AW-1:0] ex_src_i,
  input logic                       ex_br_taken_i,
  input logic [AW-1:0]              mem_rd_i,
  input logic                       mem_we_i,
  input logic                       mem_ld_i,
  input logic [NUM_SRC-1:0][1:0]    ex_fwd_sel_o,
  input logic                       pc_hold_o,
  input logic                       ifid_hold_o,
  input logic                       idex_hold_o,
  input logic                       ifid_clear_o,
  input logic                       idex_clear_o,
  input logic                       exmem_clear_o,
  input logic                       redirect_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
    // R3: a live non-load memory match selects the memory path
    p_mem_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_i && !mem_ld_i && (mem_rd_i != '0) && (mem_rd_i == ex_src_i[g]))
        |-> (ex_fwd_sel_o[g] == 2'b10));
    // R4: source 0 always reads the register file
    p_zero_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_src_i[g] == '0) |-> (ex_fwd_sel_o[g] == 2'b00));
    // R6: a load in memory never feeds the memory path
    p_no_load_fwd_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_ld_i |-> (ex_fwd_sel_o[g] != 2'b10));
  end

  // R5: a stall holds the front end and bubbles memory without clearing ahead
  p_stall_shape_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold_o |-> (ifid_hold_o && idex_hold_o && exmem_clear_o && !ifid_clear_o && !idex_clear_o));
  // R8: an accepted taken decision redirects on the next cycle
  p_redirect_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_br_taken_i && !pc_hold_o && !redirect_o) |=> redirect_o);
  // R8: a redirect clears all younger stages
  p_redirect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (ifid_clear_o && idex_clear_o && exmem_clear_o));
  // R9: no redirect right after a stall cycle
  p_stall_defers_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pc_hold_o |=> !redirect_o);
  // R10: redirect overrides any hold
  p_flush_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (!pc_hold_o && !ifid_hold_o && !idex_hold_o));
  // R11: wrong-path decision cannot chain a second redirect
  p_single_redirect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |=> !redirect_o);
endmodule

bind hz_unit hz_unit_chk #(.AW(AW), .NUM_SRC(NUM_SRC)) u_chk (.*);

// File: tb/hz_unit_tb_top.sv
module hz_unit_tb_top;
  localparam int AW = 5;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic [NS-1:0][AW-1:0] id_src, ex_src;
  logic ex_tkn, mem_we, mem_ld, wb_we;
  logic [AW-1:0] mem_rd, wb_rd;
  logic [NS-1:0][1:0] sel;
  logic [NS-1:0] byp;
  logic pc_h, ifid_h, idex_h, ifid_c, idex_c, exmem_c, redir;

  hz_unit #(.AW(AW), .NUM_SRC(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .id_src_i(id_src), .ex_src_i(ex_src),
    .ex_br_taken_i(ex_tkn), .mem_rd_i(mem_rd), .mem_we_i(mem_we),
    .mem_ld_i(mem_ld), .wb_rd_i(wb_rd), .wb_we_i(wb_we),
    .ex_fwd_sel_o(sel), .id_wb_byp_o(byp), .pc_hold_o(pc_h),
    .ifid_hold_o(ifid_h), .idex_hold_o(idex_h), .ifid_clear_o(ifid_c),
    .idex_clear_o(idex_c), .exmem_clear_o(exmem_c), .redirect_o(redir)
  );

  typedef struct packed {
    logic [1:0] s0;
    logic [1:0] s1;
    logic [1:0] byp;
    logic [2:0] holds;   // pc, ifid, idex
    logic [2:0] clears;  // ifid, idex, exmem
    logic       redir;
  } obs_t;

  obs_t  exp_q [$];
  string tag_q [$];
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit model_red = 1'b0;

  function automatic logic [1:0] exp_sel(logic [AW-1:0] s, logic [AW-1:0] mrd, logic mwe,
                                         logic mld, logic [AW-1:0] wrd, logic wwe);
    if (mwe && mrd != 0 && mrd == s && !mld) return 2'b10;
    if (wwe && wrd != 0 && wrd == s) return 2'b01;
    return 2'b00;
  endfunction

  // Driver: applies one cycle of pipeline fields and queues the expected outputs.
  task automatic step(logic [AW-1:0] e0, logic [AW-1:0] e1, logic [AW-1:0] d0, logic [AW-1:0] d1,
                      logic [AW-1:0] mrd, logic mwe, logic mld,
                      logic [AW-1:0] wrd, logic wwe, logic tkn, string tag);
    obs_t e;
    logic lu, st, cur;
    @(posedge clk);
    #2;
    ex_src[0] = e0; ex_src[1] = e1; id_src[0] = d0; id_src[1] = d1;
    mem_rd = mrd; mem_we = mwe; mem_ld = mld; wb_rd = wrd; wb_we = wwe; ex_tkn = tkn;
    cur = model_red;
    lu = mld && mwe && mrd != 0 && (mrd == e0 || mrd == e1);
    st = lu && !cur;
    e.s0 = exp_sel(e0, mrd, mwe, mld, wrd, wwe);
    e.s1 = exp_sel(e1, mrd, mwe, mld, wrd, wwe);
    e.byp = {wwe && wrd != 0 && wrd == d1, wwe && wrd != 0 && wrd == d0};
    e.holds = {st, st, st};
    e.clears = {cur, cur, cur || st};
    e.redir = cur;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    model_red = tkn && !st && !cur;
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Monitor: samples at the falling edge, away from the active edge.
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      obs_t a, e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a.s0 = sel[0]; a.s1 = sel[1]; a.byp = byp;
      a.holds = {pc_h, ifid_h, idex_h};
      a.clears = {ifid_c, idex_c, exmem_c};
      a.redir = redir;
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s actual=%h expected=%h (s0 s1 byp holds clears redir)", t, a, e);
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    ex_src = '0; id_src = '0; ex_tkn = 0; mem_rd = '0; mem_we = 0; mem_ld = 0;
    wb_rd = '0; wb_we = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (redir !== 1'b0 || exmem_c !== 1'b0) begin
      failures++;
      $display("FAIL R12 in reset actual=%b%b expected=00", redir, exmem_c);
    end
    @(posedge clk); #1; rst_n = 1'b1;

    idle("R12 idle after reset");
    step(5, 0, 0, 0, 5, 1, 0, 0, 0, 0, "R1 mem fwd src0");
    step(0, 7, 0, 0, 7, 1, 0, 0, 0, 0, "R1 mem fwd src1");
    step(3, 2, 0, 0, 1, 1, 0, 3, 1, 0, "R2 wb fwd");
    step(9, 9, 0, 0, 9, 1, 0, 9, 1, 0, "R3 mem over wb");
    step(0, 0, 0, 0, 0, 1, 0, 0, 1, 0, "R4 register zero");
    step(6, 6, 0, 0, 6, 0, 0, 6, 0, 0, "R4 write bits clear");
    step(1, 4, 0, 0, 4, 1, 1, 0, 0, 0, "R5 load-use stall");
    step(6, 2, 0, 0, 6, 1, 1, 6, 1, 0, "R6 load never mem path");
    step(6, 2, 0, 0, 0, 0, 0, 6, 1, 0, "R6 loaded value from wb");
    step(0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R5 load to reg 0 no stall");
    step(0, 0, 8, 0, 0, 0, 0, 8, 1, 0, "R7 decode bypass");
    step(0, 0, 0, 8, 0, 0, 0, 0, 1, 0, "R7 zero no bypass");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 taken raised");
    idle("R8 redirect cycle");
    idle("R8 single cycle");
    step(3, 0, 0, 0, 3, 1, 1, 0, 0, 1, "R9 taken during stall");
    idle("R9 no redirect");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R10 taken raised");
    step(2, 0, 0, 0, 2, 1, 1, 0, 0, 0, "R10 flush beats stall");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 taken raised");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R11 wrong-path taken");
    idle("R11 ignored");

    for (int i = 0; i < 400; i++) begin
      step(AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
           AW'($urandom_range(0, 3)), AW'($urandom_range(0, 3)),
           AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           AW'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 3) == 0), "R1 R3 R5 R8 sweep");
    end
    idle("R8 sweep drain");
    while (exp_q.size() > 0) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule